// File: doc/BRIEF.md
# Fetch Address Selector

This block sits at the front of a five-stage pipelined processor and decides, every cycle, which address the fetch stage reads. No program counter is kept as architectural state. Instead, the block holds a predicted address in a fetch pipeline register. Each cycle it chooses one of three addresses: that prediction, a fall-through address for a conditional jump that turned out wrong, or a return address that a return instruction loaded from memory.

From the instruction currently being fetched, the block also forms the prediction for the following cycle. Conditional jumps, unconditional jumps and calls are all predicted to go to their target constant. Any other instruction is predicted to continue at the selected address plus its byte length.

Every term in the selection comes from a pipeline register of a later stage. The choice therefore never waits on a result that the current instruction is still computing. Instruction decoding, length calculation and memory access happen elsewhere and arrive as plain inputs.

Top module: `fetch_pc_select`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `f_pred` is 0, and with no override active `f_pc` is 0.
- R2: When `m_jcc` is 1 and `m_cond` is 0 (conditional jump found not taken in the memory stage), `f_pc` equals `m_fallthru` in the same cycle.
- R3: When `w_ret` is 1 and R2 does not apply, `f_pc` equals `w_retaddr` in the same cycle.
- R4: When R2 and R3 apply together, the fall-through address wins and `f_pc` equals `m_fallthru`.
- R5: When neither override applies, `f_pc` equals the registered prediction `f_pred`.
- R6: `f_kind` encodes 0 = other, 1 = unconditional jump, 2 = conditional jump, 3 = call. For kinds 1, 2 and 3, `f_pred_next` equals `f_target`.
- R7: For kind 0, `f_pred_next` equals `f_pc + f_len`, taken modulo 2^AW, with `f_len` zero-extended.
- R8: While `f_stall` is 1, `f_pred` keeps its value across the clock edge, even when an override is steering `f_pc`.
- R9: A conditional jump in the memory stage whose condition is true (`m_jcc`=1, `m_cond`=1) changes nothing, and `f_pc` stays equal to `f_pred`.
- R10: When `f_stall` is 0, `f_pred` loads `f_pred_next` at the clock edge. The prediction is built from the overridden address, so after a recovery fetch resumes sequentially from the fall-through address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| f_stall | input | 1 | Fetch stage stalled; hold the prediction |
| f_kind | input | 2 | Class of the instruction being fetched (encoding in R6) |
| f_target | input | AW | Target constant of the fetched jump or call |
| f_len | input | LW | Byte length of the fetched instruction |
| m_jcc | input | 1 | Memory stage holds a conditional jump |
| m_cond | input | 1 | Evaluated condition of that jump |
| m_fallthru | input | AW | Fall-through address carried with that jump |
| w_ret | input | 1 | Write-back stage holds a return |
| w_retaddr | input | AW | Return address read from data memory |
| f_pc | output | AW | Address fetched this cycle |
| f_pred | output | AW | Registered predicted address |
| f_pred_next | output | AW | Prediction to be registered at the next edge |

## Verification
The bound checker examines the selection and the prediction register on every cycle. It covers override priority, fall-through recovery, the return path, the pass-through of the prediction, target and sequential prediction, and holding during a stall. The directed scenarios are the only place that shows longer chains. These include fetch continuing from the fall-through address after a recovery, a taken conditional jump that leaves the flow alone, address wrap at the top of the space, and the reset value seen at the ports.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_JMP   = 2'd1,
      KIND_JCC   = 2'd2,
      KIND_CALL  = 2'd3
   } instr_kind_e;

   typedef enum logic [1:0] {
      SRC_PRED    = 2'd0,
      SRC_RECOVER = 2'd1,
      SRC_RETURN  = 2'd2
   } pc_src_e;

endpackage

// File: rtl/pcsel_recover.sv
module pcsel_recover
   import pcsel_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          m_jcc,
   input  logic          m_cond,
   input  logic [AW-1:0] m_fallthru,
   input  logic          w_ret,
   input  logic [AW-1:0] w_retaddr,
   input  logic [AW-1:0] pred_q,
   output pc_src_e       src,
   output logic [AW-1:0] pc
);

   logic mispredict;

   assign mispredict = m_jcc & ~m_cond;

   // Wrong-path recovery outranks a returning instruction.
   always_comb begin
      if (mispredict)
         src = SRC_RECOVER;
      else if (w_ret)
         src = SRC_RETURN;
      else
         src = SRC_PRED;
   end

   always_comb begin
      unique case (src)
         SRC_RECOVER: pc = m_fallthru;
         SRC_RETURN:  pc = w_retaddr;
         default:     pc = pred_q;
      endcase
   end

endmodule

// File: rtl/pcsel_predict.sv
module pcsel_predict
   import pcsel_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 4
) (
   input  logic [1:0]    kind,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] target,
   input  logic [LW-1:0] len,
   output logic [AW-1:0] next_pred
);

   localparam int PAD = AW - LW;

   logic [AW-1:0] len_ext;
   logic [AW-1:0] seq_pc;
   logic          use_target;

   generate
      if (PAD > 0) begin : g_pad
         assign len_ext = {{PAD{1'b0}}, len};
      end else begin : g_nopad
         assign len_ext = len[AW-1:0];
      end
   endgenerate

   assign seq_pc = pc + len_ext;

   always_comb begin
      unique case (instr_kind_e'(kind))
         KIND_JMP, KIND_JCC, KIND_CALL: use_target = 1'b1;
         default:                       use_target = 1'b0;
      endcase
   end

   assign next_pred = use_target ? target : seq_pc;

endmodule

// File: rtl/pcsel_pred_reg.sv
module pcsel_pred_reg #(
   parameter int          AW        = 32,
   parameter logic [AW-1:0] RESET_PC = '0,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] q
);

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RESET_PC;
            else if (!hold)
               q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RESET_PC;
            else if (!hold)
               q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
   import pcsel_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LW        = 4,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          f_stall,
   input  logic [1:0]    f_kind,
   input  logic [AW-1:0] f_target,
   input  logic [LW-1:0] f_len,
   input  logic          m_jcc,
   input  logic          m_cond,
   input  logic [AW-1:0] m_fallthru,
   input  logic          w_ret,
   input  logic [AW-1:0] w_retaddr,
   output logic [AW-1:0] f_pc,
   output logic [AW-1:0] f_pred,
   output logic [AW-1:0] f_pred_next
);

   localparam logic [AW-1:0] RESET_PC = '0;

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("fetch_pc_select: AW must lie in 8..64");
      end
      if (LW < 1 || LW >= AW) begin : g_bad_lw
         $error("fetch_pc_select: LW must lie in 1..AW-1");
      end
   endgenerate

   pc_src_e src;

   pcsel_pred_reg #(
      .AW(AW), .RESET_PC(RESET_PC), .ASYNC_RST(ASYNC_RST)
   ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (f_stall),
      .d    (f_pred_next),
      .q    (f_pred)
   );

   pcsel_recover #(.AW(AW)) u_sel (
      .m_jcc     (m_jcc),
      .m_cond    (m_cond),
      .m_fallthru(m_fallthru),
      .w_ret     (w_ret),
      .w_retaddr (w_retaddr),
      .pred_q    (f_pred),
      .src       (src),
      .pc        (f_pc)
   );

   pcsel_predict #(.AW(AW), .LW(LW)) u_pred (
      .kind     (f_kind),
      .pc       (f_pc),
      .target   (f_target),
      .len      (f_len),
      .next_pred(f_pred_next)
   );

endmodule

// File: rtl/pcsel_chk.sv
module pcsel_chk #(
   parameter int AW = 32,
   parameter int LW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          f_stall,
   input logic [1:0]    f_kind,
   input logic [AW-1:0] f_target,
   input logic [LW-1:0] f_len,
   input logic          m_jcc,
   input logic          m_cond,
   input logic [AW-1:0] m_fallthru,
   input logic          w_ret,
   input logic [AW-1:0] w_retaddr,
   input logic [AW-1:0] f_pc,
   input logic [AW-1:0] f_pred,
   input logic [AW-1:0] f_pred_next
);

   logic [AW-1:0] seq_expect;
   assign seq_expect = f_pc + AW'(f_len);

   // R2 R4
   recover_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_jcc && !m_cond) |-> (f_pc == m_fallthru));

   // R3
   return_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ret && !(m_jcc && !m_cond)) |-> (f_pc == w_retaddr));

   // R5 R9
   pred_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_ret && !(m_jcc && !m_cond)) |-> (f_pc == f_pred));

   // R6
   target_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_stall && f_kind != 2'd0) |=> (f_pred == $past(f_target)));

   // R7
   seq_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_stall && f_kind == 2'd0) |=> (f_pred == $past(seq_expect)));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_stall |=> $stable(f_pred));

endmodule

bind fetch_pc_select pcsel_chk #(.AW(AW), .LW(LW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .f_stall    (f_stall),
   .f_kind     (f_kind),
   .f_target   (f_target),
   .f_len      (f_len),
   .m_jcc      (m_jcc),
   .m_cond     (m_cond),
   .m_fallthru (m_fallthru),
   .w_ret      (w_ret),
   .w_retaddr  (w_retaddr),
   .f_pc       (f_pc),
   .f_pred     (f_pred),
   .f_pred_next(f_pred_next)
);

// File: tb/tb_fetch_pc_select.sv
`timescale 1ns/1ps
module tb_fetch_pc_select;

   localparam int AW = 32;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          f_stall;
   logic [1:0]    f_kind;
   logic [AW-1:0] f_target;
   logic [LW-1:0] f_len;
   logic          m_jcc, m_cond;
   logic [AW-1:0] m_fallthru;
   logic          w_ret;
   logic [AW-1:0] w_retaddr;
   logic [AW-1:0] f_pc, f_pred, f_pred_next;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   fetch_pc_select #(.AW(AW), .LW(LW)) dut (.*);

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic quiet();
      f_stall = 0; f_kind = 2'd0; f_target = '0; f_len = '0;
      m_jcc = 0; m_cond = 0; m_fallthru = '0; w_ret = 0; w_retaddr = '0;
   endtask

   // advance one edge, then settle away from it
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_instr(input logic [1:0] k, input logic [AW-1:0] tgt, input logic [LW-1:0] l);
      f_kind = k; f_target = tgt; f_len = l;
      #0.5;
   endtask

   task automatic t_reset();
      quiet();
      rst_n = 0;
      set_instr(2'd1, 32'h0000_0abc, 4'd0);
      tick();
      chk("R1 pred in reset", f_pred, '0);
      chk("R1 pc in reset", f_pc, '0);
      @(negedge clk);
      rst_n = 1;
      quiet();
      #0.5;
      chk("R1 pred after reset", f_pred, '0);
      chk("R1 pc after reset", f_pc, '0);
      tick();
   endtask

   task automatic t_sequential();
      set_instr(2'd0, 32'h0, 4'd3);
      chk("R7 seq next", f_pred_next, f_pc + 3);
      tick();
      chk("R5 pc follows pred", f_pc, 32'd3);
      chk("R10 pred loaded", f_pred, 32'd3);
      set_instr(2'd0, 32'hdead_0000, 4'd5);
      chk("R7 seq next ignores target", f_pred_next, 32'd8);
      tick();
      chk("R5 pc follows pred", f_pc, 32'd8);
   endtask

   task automatic t_jumps();
      set_instr(2'd1, 32'h0000_0100, 4'd9);
      chk("R6 jmp target", f_pred_next, 32'h100);
      tick();
      chk("R6 jmp fetched", f_pc, 32'h100);
      set_instr(2'd3, 32'h0000_0200, 4'd9);
      chk("R6 call target", f_pred_next, 32'h200);
      tick();
      set_instr(2'd2, 32'h0000_0300, 4'd9);
      chk("R6 jcc predicted taken", f_pred_next, 32'h300);
      tick();
      chk("R6 jcc fetched", f_pc, 32'h300);
   endtask

   task automatic t_stall();
      f_stall = 1;
      set_instr(2'd0, 32'h0, 4'd4);
      tick();
      chk("R8 hold 1", f_pred, 32'h300);
      tick();
      chk("R8 hold 2", f_pred, 32'h300);
      // override during stall still must not load the register
      w_ret = 1; w_retaddr = 32'h0000_7000;
      #0.5;
      chk("R3 ret during stall", f_pc, 32'h7000);
      tick();
      chk("R8 hold with override", f_pred, 32'h300);
      w_ret = 0; f_stall = 0;
      #0.5;
      tick();
      chk("R8 release loads", f_pred, 32'h304);
   endtask

   task automatic t_mispredict();
      m_jcc = 1; m_cond = 0; m_fallthru = 32'h0000_1234;
      set_instr(2'd0, 32'h0, 4'd2);
      chk("R2 fallthrough selected", f_pc, 32'h1234);
      chk("R10 pred from fallthrough", f_pred_next, 32'h1236);
      tick();
      m_jcc = 0;
      #0.5;
      chk("R10 resume after recovery", f_pc, 32'h1236);
   endtask

   task automatic t_taken();
      m_jcc = 1; m_cond = 1; m_fallthru = 32'h0000_5555;
      set_instr(2'd0, 32'h0, 4'd1);
      chk("R9 taken jcc no override", f_pc, 32'h1236);
      tick();
      chk("R9 flow continues", f_pc, 32'h1237);
      m_jcc = 0; m_cond = 0;
      #0.5;
   endtask

   task automatic t_return();
      w_ret = 1; w_retaddr = 32'h0000_0040;
      set_instr(2'd1, 32'h0000_0080, 4'd2);
      chk("R3 return addr", f_pc, 32'h40);
      tick();
      w_ret = 0;
      #0.5;
      chk("R3 flow after ret", f_pc, 32'h80);
   endtask

   task automatic t_combo();
      w_ret = 1; w_retaddr = 32'h0000_0aaa;
      m_jcc = 1; m_cond = 0; m_fallthru = 32'h0000_0bbb;
      set_instr(2'd0, 32'h0, 4'd1);
      chk("R4 recovery beats return", f_pc, 32'hbbb);
      tick();
      quiet();
      #0.5;
      chk("R4 continues from fallthrough", f_pc, 32'hbbc);
   endtask

   task automatic t_wrap();
      set_instr(2'd1, 32'hffff_fffe, 4'd0);
      tick();
      set_instr(2'd0, 32'h0, 4'd4);
      chk("R7 wraps modulo", f_pred_next, 32'h2);
      tick();
      chk("R7 wrapped pc", f_pc, 32'h2);
   endtask

   initial begin
      quiet();
      rst_n = 0;
      t_reset();
      t_sequential();
      t_jumps();
      t_stall();
      t_mispredict();
      t_taken();
      t_return();
      t_combo();
      t_wrap();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule